// File: doc/BRIEF.md
# Configurable Absolute-Difference Accumulator Cluster

This block is a coarse-grained arithmetic cell for a reconfigurable fabric aimed at block-matching motion search. Its front end is a set of 8-bit lanes, two by default. Each lane adds or subtracts with a carry. Each lane can instead return the magnitude of the difference of two unsigned pixels. The lanes can work on their own or be chained into one 16-bit unit. Behind the lanes sits a 16-bit accumulator. It either sums the front-end result into an internal register on each enabled clock, or acts as a plain combinational adder/subtracter with a side operand.

A short internal path feeds the accumulator directly. With the lanes chained, it carries the 16-bit front-end value. With the lanes separate, it carries the zero-extended sum of the lane results, which gives two pixel differences per clock for a sum-of-absolute-differences search. A 7-bit configuration word, written through a small address/data port, selects the mode and the operation. It also selects whether the result is registered and whether the lanes are chained. A unit left unconfigured is quiescent: its operands are isolated, its registers hold and its result stays frozen.

Top module: `adacc_cluster`

## Requirements
- R1: After reset the configuration is all zero (mode off), `result` is 0, and `cout` and `acc_cout` are 0.
- R2: A write with `cfg_we`=1 and `cfg_addr`=0 loads `cfg_wdata` at the clock edge and takes effect from the next cycle. Writes to any other address change nothing. Fields: bits[1:0] mode (0 off, 1 lane result, 2 sequential accumulate, 3 combinational accumulator), bit2 lane subtract, bit3 absolute difference, bit4 chain lanes, bit5 accumulator subtract, bit6 register the result.
- R3: In mode 1 with the lanes unchained, each 8-bit lane i gives a_i + b_i + cin, or a_i + ~b_i + cin when subtracting, modulo 256. The lanes are packed with lane 0 in bits[7:0]. `cout` is the carry out of lane 0.
- R4: With the lanes chained, the result is the 16-bit a + b + cin, or a + ~b + cin when subtracting. `cout` is the carry out of bit 15.
- R5: With bit3 set, the lane result is |a−b| of unsigned operands, per lane or over 16 bits when chained, and `cin` is ignored. `cout` is 1 exactly when a ≥ b (lane 0, or the full word when chained).
- R6: In mode 2, each clock edge with `en`=1 loads acc + feed + `acc_cin` modulo 2^16, or acc + ~feed + `acc_cin` when bit5 is set. `result` shows the register. `acc_cout` shows the carry out of that sum for the current inputs. feed is the 16-bit front result when chained, and the zero-extended sum of the lane results otherwise.
- R7: In mode 2, `clr`=1 zeroes the accumulator at the next edge, whatever `en` is. With `en`=0 and `clr`=0 the accumulator holds.
- R8: In mode 3, `result` is `acc_x` + feed + `acc_cin` (or `acc_x` + ~feed + `acc_cin`) modulo 2^16, combinationally, and `acc_cout` is bit 16 of that sum.
- R9: With bit6 set, `result` is the combinational value of the previous cycle, one clock later.
- R10: In mode 0, `result` holds the value it showed in the last active cycle, and `cout` and `acc_cout` are 0. The accumulator ignores `clr` and `en`, so its value is unchanged when the unit is re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address, only 0 is decoded |
| cfg_wdata | input | 7 | Configuration word |
| op_a | input | 16 | Operand A, lane i in bits [8i+7:8i] |
| op_b | input | 16 | Operand B, lane layout as op_a |
| cin | input | 1 | Lane carry input / cascade in |
| acc_x | input | 16 | Side operand of the combinational accumulator |
| acc_cin | input | 1 | Accumulator carry input / cascade in |
| en | input | 1 | Accumulate enable |
| clr | input | 1 | Synchronous accumulator clear |
| result | output | 16 | Cluster result |
| cout | output | 1 | Lane carry output / cascade out |
| acc_cout | output | 1 | Accumulator carry output / cascade out |

## Verification
The assertions assume a configuration write never coincides with a cycle whose registered-output or hold property is being judged, so they condition on `cfg_we` being low. They also assume the operands are unsigned pixel codes. The bench writes the configuration only with `en` and `clr` low, then drives operands and control away from the clock edge, holding them across each edge it judges. Accumulator runs use operands chosen so the sum wraps past 2^16 inside the run.

// File: rtl/adacc_pkg.sv
package adacc_pkg;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_LANE     = 2'd1,
    MODE_ACC_SEQ  = 2'd2,
    MODE_ACC_COMB = 2'd3
  } adacc_mode_e;

  typedef struct packed {
    logic        out_reg;
    logic        acc_sub;
    logic        chain;
    logic        absd;
    logic        sub;
    adacc_mode_e mode;
  } adacc_cfg_t;

  localparam int CFG_W = $bits(adacc_cfg_t);

endpackage

// File: rtl/adacc_cfg_reg.sv
module adacc_cfg_reg
  import adacc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  wdata,
  output adacc_cfg_t        cfg_q
);

  logic hit;
  assign hit = we && (addr == MY_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cfg_q <= '0;
    else if (hit) cfg_q <= adacc_cfg_t'(wdata);
  end

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cfg_q == adacc_cfg_t'($past(wdata)))); // R2
  AST_CFG_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr != MY_ADDR) |=> $stable(cfg_q)); // R2

endmodule

// File: rtl/adacc_front.sv
module adacc_front #(
  parameter int SLICE_W = 8,
  parameter int LANES   = 2,
  localparam int WIDE_W = SLICE_W * LANES
) (
  input  logic [WIDE_W-1:0] op_a,
  input  logic [WIDE_W-1:0] op_b,
  input  logic              cin,
  input  logic              sub,
  input  logic              absd,
  input  logic              chain,
  output logic [WIDE_W-1:0] front_res,
  output logic [WIDE_W-1:0] feed,
  output logic [LANES-1:0]  lane_geq,
  output logic              cout
);

  function automatic logic [SLICE_W:0] lane_sum(input logic [SLICE_W-1:0] a,
                                                 input logic [SLICE_W-1:0] b,
                                                 input logic ci, input logic do_sub);
    return {1'b0, a} + {1'b0, (do_sub ? ~b : b)} + {{SLICE_W{1'b0}}, ci};
  endfunction

  function automatic logic [SLICE_W-1:0] lane_mag(input logic [SLICE_W-1:0] v,
                                                   input logic keep);
    return keep ? v : (~v + 1'b1);
  endfunction

  function automatic logic [WIDE_W-1:0] wide_mag(input logic [WIDE_W-1:0] v,
                                                  input logic keep);
    return keep ? v : (~v + 1'b1);
  endfunction

  logic              eff_sub;
  logic              free_ci;
  logic [LANES-1:0]  c_out;
  logic [WIDE_W-1:0] raw;
  logic [WIDE_W-1:0] abs_lanes;
  logic [WIDE_W-1:0] abs_wide;

  // The magnitude stage always works on a - b with no incoming borrow.
  assign eff_sub = sub | absd;
  assign free_ci = absd ? 1'b1 : cin;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic             ci;
    logic [SLICE_W:0] s;
    if (g == 0) begin : g_first
      assign ci = free_ci;
    end else begin : g_rest
      assign ci = chain ? c_out[g-1] : free_ci;
    end
    assign s = lane_sum(op_a[g*SLICE_W +: SLICE_W], op_b[g*SLICE_W +: SLICE_W], ci, eff_sub);
    assign raw[g*SLICE_W +: SLICE_W]       = s[SLICE_W-1:0];
    assign c_out[g]                        = s[SLICE_W];
    assign abs_lanes[g*SLICE_W +: SLICE_W] = lane_mag(s[SLICE_W-1:0], s[SLICE_W]);
  end

  assign lane_geq = c_out;
  assign abs_wide = wide_mag(raw, c_out[LANES-1]);

  always_comb begin
    if (!absd)      front_res = raw;
    else if (chain) front_res = abs_wide;
    else            front_res = abs_lanes;
  end

  assign cout = chain ? c_out[LANES-1] : c_out[0];

  // Short path into the accumulator: whole word when chained, lane sum otherwise.
  always_comb begin
    if (chain) begin
      feed = front_res;
    end else begin
      feed = '0;
      for (int i = 0; i < LANES; i++)
        feed = feed + WIDE_W'(front_res[i*SLICE_W +: SLICE_W]);
    end
  end

endmodule

// File: rtl/adacc_accum.sv
module adacc_accum #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_mode,
  input  logic             en,
  input  logic             clr,
  input  logic             sub,
  input  logic             cin,
  input  logic [ACC_W-1:0] feed,
  input  logic [ACC_W-1:0] side,
  output logic [ACC_W-1:0] acc_val,
  output logic             acc_cout
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] base;
  logic [ACC_W:0]   sum;

  assign base = seq_mode ? acc_q : side;
  assign sum  = {1'b0, base} + {1'b0, (sub ? ~feed : feed)} + {{ACC_W{1'b0}}, cin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (seq_mode) begin
      if (clr)     acc_q <= '0;
      else if (en) acc_q <= sum[ACC_W-1:0];
    end
  end

  assign acc_val  = seq_mode ? acc_q : sum[ACC_W-1:0];
  assign acc_cout = sum[ACC_W];

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && clr) |=> (acc_q == '0)); // R7
  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && !en && !clr) |=> $stable(acc_q)); // R7
  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_mode |=> $stable(acc_q)); // R10

endmodule

// File: rtl/adacc_cluster.sv
module adacc_cluster
  import adacc_pkg::*;
#(
  parameter int SLICE_W    = 8,
  parameter int LANES      = 2,
  parameter int CFG_ADDR_W = 2,
  localparam int ACC_W     = SLICE_W * LANES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]      cfg_wdata,
  input  logic [ACC_W-1:0]      op_a,
  input  logic [ACC_W-1:0]      op_b,
  input  logic                  cin,
  input  logic [ACC_W-1:0]      acc_x,
  input  logic                  acc_cin,
  input  logic                  en,
  input  logic                  clr,
  output logic [ACC_W-1:0]      result,
  output logic                  cout,
  output logic                  acc_cout
);

  adacc_cfg_t       cfg;
  logic             unit_off;
  logic             is_seq;
  logic             is_acc;
  logic [ACC_W-1:0] a_g;
  logic [ACC_W-1:0] b_g;
  logic [ACC_W-1:0] x_g;
  logic [ACC_W-1:0] front_res;
  logic [ACC_W-1:0] feed;
  logic [LANES-1:0] lane_geq;
  logic             front_cout;
  logic [ACC_W-1:0] acc_val;
  logic             acc_c;
  logic [ACC_W-1:0] comb_y;
  logic [ACC_W-1:0] y_q;

  adacc_cfg_reg #(.ADDR_W(CFG_ADDR_W), .MY_ADDR('0)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .cfg_q (cfg)
  );

  assign unit_off = (cfg.mode == MODE_OFF);
  assign is_seq   = (cfg.mode == MODE_ACC_SEQ);
  assign is_acc   = is_seq || (cfg.mode == MODE_ACC_COMB);

  // Operand isolation keeps an unconfigured unit from toggling.
  assign a_g = unit_off ? '0 : op_a;
  assign b_g = unit_off ? '0 : op_b;
  assign x_g = is_acc   ? acc_x : '0;

  adacc_front #(.SLICE_W(SLICE_W), .LANES(LANES)) u_front (
    .op_a      (a_g),
    .op_b      (b_g),
    .cin       (cin),
    .sub       (cfg.sub),
    .absd      (cfg.absd),
    .chain     (cfg.chain),
    .front_res (front_res),
    .feed      (feed),
    .lane_geq  (lane_geq),
    .cout      (front_cout)
  );

  adacc_accum #(.ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .seq_mode (is_seq),
    .en       (en),
    .clr      (clr),
    .sub      (cfg.acc_sub),
    .cin      (acc_cin),
    .feed     (feed),
    .side     (x_g),
    .acc_val  (acc_val),
    .acc_cout (acc_c)
  );

  always_comb begin
    unique case (cfg.mode)
      MODE_LANE:     comb_y = front_res;
      MODE_ACC_SEQ:  comb_y = acc_val;
      MODE_ACC_COMB: comb_y = acc_val;
      default:       comb_y = y_q;
    endcase
  end

  // Tracks every active cycle, so it serves as the optional output flop
  // and as the frozen value of an unconfigured unit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         y_q <= '0;
    else if (!unit_off) y_q <= comb_y;
  end

  assign result   = (unit_off || cfg.out_reg) ? y_q : comb_y;
  assign cout     = unit_off ? 1'b0 : front_cout;
  assign acc_cout = is_acc ? acc_c : 1'b0;

  AST_ABS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.absd && !cfg.chain && !unit_off) |->
      (front_res[SLICE_W-1:0] <= ((op_a[SLICE_W-1:0] > op_b[SLICE_W-1:0]) ?
                                  op_a[SLICE_W-1:0] : op_b[SLICE_W-1:0]))); // R5
  AST_ABS_EQUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.absd && !unit_off && op_a == op_b) |-> (front_res == '0 && lane_geq == '1)); // R5
  AST_OUTREG_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.out_reg && !unit_off && !cfg_we) |=> (result == $past(comb_y))); // R9
  AST_OFF_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_off && !cfg_we) |=> $stable(result)); // R10
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    unit_off |-> (!cout && !acc_cout)); // R10

endmodule

// File: tb/tb_adacc_cluster.sv
module tb_adacc_cluster;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [6:0]  cfg_wdata;
  logic [15:0] op_a, op_b, acc_x;
  logic        cin, acc_cin, en, clr;
  logic [15:0] result;
  logic        cout, acc_cout;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adacc_cluster dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .op_a(op_a), .op_b(op_b), .cin(cin), .acc_x(acc_x), .acc_cin(acc_cin),
    .en(en), .clr(clr), .result(result), .cout(cout), .acc_cout(acc_cout)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  // Independent arithmetic model of the front end and the feed path.
  function automatic void ref_front(input logic [6:0] cf, input logic [15:0] a, input logic [15:0] b,
                                    input logic ci, output logic [15:0] val, output logic co,
                                    output logic [15:0] fd);
    int x, y, s;
    int lv[2];
    int lc[2];
    if (cf[4]) begin
      x = int'(a); y = int'(b);
      if (cf[3]) begin
        s  = (x >= y) ? x - y : y - x;
        co = (x >= y);
      end else begin
        s  = x + (cf[2] ? 65535 - y : y) + int'(ci);
        co = s[16];
      end
      val = s[15:0];
      fd  = val;
    end else begin
      for (int k = 0; k < 2; k++) begin
        x = (int'(a) >> (8 * k)) & 255;
        y = (int'(b) >> (8 * k)) & 255;
        if (cf[3]) begin
          lv[k] = (x >= y) ? x - y : y - x;
          lc[k] = (x >= y) ? 1 : 0;
        end else begin
          s     = x + (cf[2] ? 255 - y : y) + int'(ci);
          lv[k] = s & 255;
          lc[k] = s >> 8;
        end
      end
      val = {lv[1][7:0], lv[0][7:0]};
      co  = lc[0][0];
      s   = lv[0] + lv[1];
      fd  = s[15:0];
    end
  endfunction

  task automatic wr_cfg(input logic [1:0] ad, input logic [6:0] d);
    cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = 7'd0;
  endtask

  // Sweep over lane values including 0 and 255, in lane or comb-accumulator mode.
  task automatic sweep(input logic [6:0] cf, input string req);
    logic [15:0] v, fd, ex;
    logic        co;
    int          s;
    wr_cfg(2'd0, cf);
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        op_a    = {8'((i * 37 + 11) & 255), 8'(i * 17)};
        op_b    = {8'((j * 53 + 200) & 255), 8'(j * 17)};
        cin     = 1'((i + j) & 1);
        acc_x   = 16'((i * 4099 + j * 257) & 16'hFFFF);
        acc_cin = 1'((i ^ j) & 1);
        #1;
        ref_front(cf, op_a, op_b, cin, v, co, fd);
        if (cf[1:0] == 2'd1) begin
          chk({req, " result"}, result, v);
          chk({req, " cout"}, cout, co);
        end else begin
          s  = int'(acc_x) + (cf[5] ? 65535 - int'(fd) : int'(fd)) + int'(acc_cin);
          ex = s[15:0];
          chk({req, " result"}, result, ex);
          chk({req, " acc_cout"}, acc_cout, s[16]);
        end
      end
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 200000 && !done) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v, fd, acc_m, prev;
    logic        co;
    int          s;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = 7'd0;
    op_a = '0; op_b = '0; acc_x = '0; cin = 1'b0; acc_cin = 1'b0; en = 1'b0; clr = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk("R1 reset result", result, 16'h0);
    chk("R1 reset cout", cout, 1'b0);
    chk("R1 reset acc_cout", acc_cout, 1'b0);

    // R2: address 0 loads, other addresses are ignored.
    wr_cfg(2'd0, 7'h01);
    op_a = 16'h1234; op_b = 16'h0101; #1;
    chk("R2 load addr0", result, 16'h1335);
    wr_cfg(2'd1, 7'h00);
    wr_cfg(2'd3, 7'h00);
    op_a = 16'h2020; op_b = 16'h0303; #1;
    chk("R2 other addr ignored", result, 16'h2323);

    sweep(7'h01, "R3 lane add");
    sweep(7'h05, "R3 lane sub");
    sweep(7'h11, "R4 chained add");
    sweep(7'h15, "R4 chained sub");
    sweep(7'h19, "R5 chained absdiff");
    sweep(7'h17, "R8 comb acc add");
    sweep(7'h2B, "R8 comb acc sub");

    // R5: exhaustive unsigned pixel pairs per lane, cin toggling.
    wr_cfg(2'd0, 7'h09);
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        op_a = {8'(a ^ 255), 8'(a)};
        op_b = {8'(b), 8'(b)};
        cin  = 1'(a + b);
        #1;
        ref_front(7'h09, op_a, op_b, cin, v, co, fd);
        chk("R5 lane absdiff", result, v);
        chk("R5 lane absdiff cout", cout, co);
      end
    end

    // R6/R7: sequential sum of absolute differences, wrapping past 2^16.
    wr_cfg(2'd0, 7'h0A);
    clr = 1'b1; en = 1'b0;
    @(posedge clk); #1;
    clr = 1'b0;
    acc_m = 16'h0;
    chk("R7 clear", result, acc_m);
    en = 1'b1; acc_cin = 1'b0;
    for (int i = 0; i < 140; i++) begin
      op_a = {8'(i % 5), 8'(255 - (i % 4))};
      op_b = {8'(255 - (i % 2)), 8'(i % 3)};
      #1;
      ref_front(7'h0A, op_a, op_b, 1'b0, v, co, fd);
      s = int'(acc_m) + int'(fd);
      chk("R6 acc_cout", acc_cout, s[16]);
      @(posedge clk); #1;
      acc_m = s[15:0];
      chk("R6 accumulate", result, acc_m);
    end
    en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      op_a = 16'(i * 4111); op_b = 16'(i * 997);
      @(posedge clk); #1;
      chk("R7 hold without enable", result, acc_m);
    end
    en = 1'b1; clr = 1'b1;
    @(posedge clk); #1;
    clr = 1'b0; en = 1'b0;
    acc_m = 16'h0;
    chk("R7 clear over enable", result, acc_m);

    wr_cfg(2'd0, 7'h2A);
    op_a = 16'h3090; op_b = 16'h4010; acc_cin = 1'b1; en = 1'b1;
    #1;
    ref_front(7'h2A, op_a, op_b, 1'b0, v, co, fd);
    @(posedge clk); #1;
    en = 1'b0; acc_cin = 1'b0;
    s = int'(acc_m) + 65535 - int'(fd) + 1;
    acc_m = s[15:0];
    chk("R6 accumulate subtract wrap", result, acc_m);

    // R10: switch off, poke controls, then re-enable.
    wr_cfg(2'd0, 7'h00);
    chk("R10 frozen result", result, acc_m);
    en = 1'b1; clr = 1'b1;
    for (int i = 0; i < 3; i++) begin
      op_a = 16'(i * 5003 + 1); op_b = 16'(i * 211); acc_cin = 1'b1;
      @(posedge clk); #1;
      chk("R10 frozen result", result, acc_m);
      chk("R10 cout quiet", cout, 1'b0);
      chk("R10 acc_cout quiet", acc_cout, 1'b0);
    end
    en = 1'b0; clr = 1'b0; acc_cin = 1'b0;
    wr_cfg(2'd0, 7'h2A);
    chk("R10 accumulator kept", result, acc_m);

    // R9: registered output lags one clock.
    wr_cfg(2'd0, 7'h51);
    prev = acc_m;
    for (int i = 0; i < 8; i++) begin
      op_a = 16'(i * 7919 + 3); op_b = 16'(i * 104729 + 5); cin = 1'(i);
      #1;
      chk("R9 before edge", result, prev);
      ref_front(7'h51, op_a, op_b, cin, v, co, fd);
      @(posedge clk); #1;
      chk("R9 after edge", result, v);
      prev = v;
    end

    done = 1;
    summary();
    $finish;
  end

endmodule